// File: doc/BRIEF.md
# Instruction Tag Queue Tracker

This block keeps breakpoint tags attached to instruction words while they wait in a short prefetch queue. Two active-low tag pins, one per byte lane, are sampled when an external bus clock falls. The sampled tag is held until the next fetch and then stored with the fetched word. The tag moves with that word toward the head of the queue.

When the word at the head is about to issue and carries a tag, the block raises a debug-entry request in place of the issue strobe and keeps the word in place. Tagging is armed by a one-cycle pulse and stays armed until debug mode goes active. While tagging is armed, the block drives a signal that holds off serial debug command processing. A flush input empties the queue and drops any tag still waiting to be attached.

Top module: `tag_queue_tracker`

## Requirements
- R1: Tag pins are sampled only when `bus_clk`, as seen at a `clk` edge, changes from 1 to 0. Pin levels at any other time leave the word's tag at 00.
- R2: A pin counts as asserted at logic 0, and the two pins are decoded independently. `head_tag[1]` is the high-byte tag, taken from `tag_hi_n`. `head_tag[0]` is the low-byte tag, taken from `tag_lo_n`. Pins (hi,lo) = (1,1) give 00, (1,0) give 01, (0,1) give 10, and (0,0) give 11.
- R3: The high-byte tag is honoured in every mode. The low-byte tag is stored only when `lstrb_mode` is 1; otherwise it reads 0.
- R4: The queue holds up to three words, in first-in first-out order. A sampled tag is attached to the next accepted fetch, and it stays with that word until the word leaves the queue.
- R5: When `issue_ready` is 1 and the head word is untagged, `issue` is 1 in that cycle and the word is removed. When the head is tagged and tagging is armed, `dbg_req` is 1 and `issue` is 0, and the word stays at the head.
- R6: A one-cycle `arm_pulse` arms tagging from the next cycle onward. `cmd_block` is 1 exactly while tagging is armed. Tags are sampled only while armed.
- R7: `dbg_active` at 1 blocks `dbg_req` in the same cycle and disarms tagging from the next cycle onward. While disarmed, a tagged head issues like an untagged one.
- R8: `flush` empties the queue and clears any pending tag, so a later fetch made without a new bus-clock fall is untagged.
- R9: A fetch that arrives while the queue is full and the head is not removed is dropped.
- R10: After reset the queue is empty, tagging is disarmed, and `issue`, `dbg_req` and `cmd_block` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | External bus clock, sampled by clk |
| tag_hi_n | input | 1 | Active-low high-byte tag pin |
| tag_lo_n | input | 1 | Active-low low-byte tag pin |
| lstrb_mode | input | 1 | Enables low-byte tagging |
| arm_pulse | input | 1 | One-cycle pulse that arms tagging |
| dbg_active | input | 1 | Debug mode is active |
| flush | input | 1 | Empties the queue and the pending tag |
| fetch_valid | input | 1 | A fetched word is presented |
| fetch_word | input | 16 | Fetched instruction word |
| issue_ready | input | 1 | The consumer wants the head word this cycle |
| head_valid | output | 1 | Queue is not empty |
| head_word | output | 16 | Word at the head |
| head_tag | output | 2 | Tag of the head word, {high, low} |
| issue | output | 1 | Head word issues and is removed |
| dbg_req | output | 1 | Tagged head reached issue; enter debug |
| cmd_block | output | 1 | Tagging armed; serial commands held off |

## Verification
The bench builds the block with its defaults: a three-entry queue of 16-bit words. At this depth, a tag placed on the middle of three words can be followed through one issue and up to the head, and a fourth fetch lands on a full queue. A table walks all four pin combinations with the low-strobe mode both on and off. Directed cases cover an unarmed sample, a held-high bus clock, debug entry in the same cycle as a tagged issue, and a flush that discards a pending tag.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  localparam int TQ_WORD_W = 16;
  localparam int TQ_DEPTH  = 3;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_tag_t;

  localparam lane_tag_t TAG_NONE = '{hi: 1'b0, lo: 1'b0};
endpackage

// File: rtl/tagq_sampler.sv
module tagq_sampler
  import tagq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_clk,
  input  logic      tag_hi_n,
  input  logic      tag_lo_n,
  input  logic      lstrb_mode,
  input  logic      clear,
  input  logic      consume,
  output lane_tag_t pend
);
  logic      bclk_q;
  logic      bus_fall;
  lane_tag_t pend_q, pend_d;

  assign bus_fall = bclk_q & ~bus_clk;

  always_comb begin
    pend_d = pend_q;
    if (clear) begin
      pend_d = TAG_NONE;
    end else if (bus_fall) begin
      pend_d.hi = ~tag_hi_n;
      pend_d.lo = ~tag_lo_n & lstrb_mode;
    end else if (consume) begin
      pend_d = TAG_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      pend_q <= TAG_NONE;
    end else begin
      bclk_q <= bus_clk;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/tagq_fifo.sv
module tagq_fifo
  import tagq_pkg::*;
#(
  parameter int DEPTH  = TQ_DEPTH,
  parameter int WORD_W = TQ_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [WORD_W-1:0] din_word,
  input  lane_tag_t         din_tag,
  output logic              push_ok,
  output logic              head_valid,
  output logic [WORD_W-1:0] head_word,
  output lane_tag_t         head_tag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WORD_W-1:0] word_q [DEPTH];
  logic [WORD_W-1:0] word_d [DEPTH];
  lane_tag_t         tag_q  [DEPTH];
  lane_tag_t         tag_d  [DEPTH];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     wr_idx;
  logic              do_pop;
  logic              full;

  assign full       = (cnt_q == FULL_CNT);
  assign head_valid = (cnt_q != '0);
  assign do_pop     = pop & head_valid & ~flush;
  assign push_ok    = push & ~flush & (~full | do_pop);
  assign wr_idx     = cnt_q - {{(CW-1){1'b0}}, do_pop};

  always_comb begin
    cnt_d = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      case ({push_ok, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [CW-1:0] IDX = CW'(i);
    always_comb begin
      word_d[i] = word_q[i];
      tag_d[i]  = tag_q[i];
      if (flush) begin
        tag_d[i] = TAG_NONE;
      end else if (push_ok && wr_idx == IDX) begin
        word_d[i] = din_word;
        tag_d[i]  = din_tag;
      end else if (do_pop) begin
        if (i < DEPTH - 1) begin
          word_d[i] = word_q[(i < DEPTH - 1) ? i + 1 : i];
          tag_d[i]  = tag_q[(i < DEPTH - 1) ? i + 1 : i];
        end else begin
          tag_d[i] = TAG_NONE;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[i] <= '0;
        tag_q[i]  <= TAG_NONE;
      end else begin
        word_q[i] <= word_d[i];
        tag_q[i]  <= tag_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign head_word = word_q[0];
  assign head_tag  = head_valid ? tag_q[0] : TAG_NONE;
endmodule

// File: rtl/tagq_ctrl.sv
module tagq_ctrl
  import tagq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_pulse,
  input  logic      dbg_active,
  input  logic      head_valid,
  input  lane_tag_t head_tag,
  input  logic      issue_ready,
  output logic      armed,
  output logic      issue,
  output logic      dbg_req
);
  logic armed_q, armed_d;
  logic head_tagged;

  always_comb begin
    armed_d = armed_q;
    if (dbg_active)     armed_d = 1'b0;
    else if (arm_pulse) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign head_tagged = head_tag.hi | head_tag.lo;
  assign dbg_req = issue_ready & head_valid & head_tagged & armed_q & ~dbg_active;
  assign issue   = issue_ready & head_valid & ~dbg_req;
  assign armed   = armed_q;
endmodule

// File: rtl/tag_queue_tracker.sv
module tag_queue_tracker
  import tagq_pkg::*;
#(
  parameter int DEPTH  = TQ_DEPTH,
  parameter int WORD_W = TQ_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              tag_hi_n,
  input  logic              tag_lo_n,
  input  logic              lstrb_mode,
  input  logic              arm_pulse,
  input  logic              dbg_active,
  input  logic              flush,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              issue_ready,
  output logic              head_valid,
  output logic [WORD_W-1:0] head_word,
  output logic [1:0]        head_tag,
  output logic              issue,
  output logic              dbg_req,
  output logic              cmd_block
);
  lane_tag_t pend_tag;
  lane_tag_t hd_tag;
  logic      armed;
  logic      push_ok;
  logic      samp_clear;

  assign samp_clear = flush | dbg_active | ~armed;

  tagq_sampler u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_clk    (bus_clk),
    .tag_hi_n   (tag_hi_n),
    .tag_lo_n   (tag_lo_n),
    .lstrb_mode (lstrb_mode),
    .clear      (samp_clear),
    .consume    (push_ok),
    .pend       (pend_tag)
  );

  tagq_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (fetch_valid),
    .pop        (issue),
    .flush      (flush),
    .din_word   (fetch_word),
    .din_tag    (pend_tag),
    .push_ok    (push_ok),
    .head_valid (head_valid),
    .head_word  (head_word),
    .head_tag   (hd_tag)
  );

  tagq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_pulse   (arm_pulse),
    .dbg_active  (dbg_active),
    .head_valid  (head_valid),
    .head_tag    (hd_tag),
    .issue_ready (issue_ready),
    .armed       (armed),
    .issue       (issue),
    .dbg_req     (dbg_req)
  );

  assign head_tag  = {hd_tag.hi, hd_tag.lo};
  assign cmd_block = armed;
endmodule

// File: rtl/tagq_checker.sv
module tagq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_pulse,
  input logic       dbg_active,
  input logic       flush,
  input logic       issue_ready,
  input logic       head_valid,
  input logic [1:0] head_tag,
  input logic       issue,
  input logic       dbg_req,
  input logic       cmd_block
);
  AST_ISSUE_OR_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && dbg_req)); // R5
  AST_DEBUG_NEEDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (head_valid && head_tag != 2'b00 && cmd_block)); // R5
  AST_TAGGED_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !flush) |=> head_valid); // R5
  AST_ARM_SETS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_pulse && !dbg_active) |=> cmd_block); // R6
  AST_DEBUG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |=> !cmd_block); // R7
  AST_DEBUG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |-> !dbg_req); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !head_valid); // R8
  AST_ISSUE_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (head_valid && issue_ready)); // R5
endmodule

bind tag_queue_tracker tagq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_pulse   (arm_pulse),
  .dbg_active  (dbg_active),
  .flush       (flush),
  .issue_ready (issue_ready),
  .head_valid  (head_valid),
  .head_tag    (head_tag),
  .issue       (issue),
  .dbg_req     (dbg_req),
  .cmd_block   (cmd_block)
);

// File: tb/tag_queue_tracker_test.sv
module tag_queue_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        bus_clk, tag_hi_n, tag_lo_n, lstrb_mode;
  logic        arm_pulse, dbg_active, flush, fetch_valid, issue_ready;
  logic [15:0] fetch_word;
  logic        head_valid, issue, dbg_req, cmd_block;
  logic [15:0] head_word;
  logic [1:0]  head_tag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // {tag_hi_n, tag_lo_n, lstrb_mode, expected head_tag[1:0]}
  localparam logic [4:0] VEC [8] = '{
    5'b11_1_00, 5'b10_1_01, 5'b01_1_10, 5'b00_1_11,
    5'b11_0_00, 5'b10_0_00, 5'b01_0_10, 5'b00_0_10
  };

  tag_queue_tracker uut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .tag_hi_n(tag_hi_n),
    .tag_lo_n(tag_lo_n), .lstrb_mode(lstrb_mode), .arm_pulse(arm_pulse),
    .dbg_active(dbg_active), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_word(fetch_word), .issue_ready(issue_ready), .head_valid(head_valid),
    .head_word(head_word), .head_tag(head_tag), .issue(issue),
    .dbg_req(dbg_req), .cmd_block(cmd_block)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_flush();
    flush = 1'b1; tick(); flush = 1'b0;
  endtask

  task automatic do_arm();
    arm_pulse = 1'b1; tick(); arm_pulse = 1'b0;
  endtask

  task automatic bus_fall(input logic hn, input logic ln);
    bus_clk = 1'b1; tick();
    tag_hi_n = hn; tag_lo_n = ln; bus_clk = 1'b0; tick();
    tag_hi_n = 1'b1; tag_lo_n = 1'b1;
  endtask

  task automatic fetch(input logic [15:0] w);
    fetch_valid = 1'b1; fetch_word = w; tick(); fetch_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_clk = 1'b0; tag_hi_n = 1'b1; tag_lo_n = 1'b1;
    lstrb_mode = 1'b1; arm_pulse = 1'b0; dbg_active = 1'b0; flush = 1'b0;
    fetch_valid = 1'b0; fetch_word = '0; issue_ready = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 head_valid", head_valid, 0);
    chk("R10 cmd_block", cmd_block, 0);
    issue_ready = 1'b1; #1;
    chk("R10 issue", issue, 0);
    chk("R10 dbg_req", dbg_req, 0);
    issue_ready = 1'b0;

    // R6 unarmed: tags not sampled
    bus_fall(1'b0, 1'b0);
    fetch(16'h1111);
    chk("R6 unarmed tag", head_tag, 2'b00);
    do_flush();

    // R2 R3 table walk
    for (int v = 0; v < 8; v++) begin
      do_flush();
      do_arm();
      chk("R6 armed cmd_block", cmd_block, 1);
      lstrb_mode = VEC[v][2];
      bus_fall(VEC[v][4], VEC[v][3]);
      fetch(16'hA000 + 16'(v));
      chk("R2 R3 head_valid", head_valid, 1);
      chk("R4 head_word", head_word, 16'hA000 + 16'(v));
      chk("R2 R3 head_tag", head_tag, VEC[v][1:0]);
      issue_ready = 1'b1; #1;
      chk("R5 dbg_req", dbg_req, |VEC[v][1:0]);
      chk("R5 issue", issue, ~|VEC[v][1:0]);
      issue_ready = 1'b0;
      dbg_active = 1'b1; tick(); dbg_active = 1'b0;
    end
    lstrb_mode = 1'b1;

    // R1 no falling edge: bus_clk held high
    do_flush();
    do_arm();
    bus_clk = 1'b1; tick();
    tag_hi_n = 1'b0; tag_lo_n = 1'b0; tick(); tick();
    fetch(16'h2222);
    tag_hi_n = 1'b1; tag_lo_n = 1'b1;
    chk("R1 no fall tag", head_tag, 2'b00);

    // R4 R5 R9 travel through queue
    do_flush();
    fetch(16'h0A0A);
    bus_fall(1'b0, 1'b1);
    fetch(16'h0B0B);
    fetch(16'h0C0C);
    fetch(16'h0D0D);  // queue full: dropped
    chk("R4 head A", head_word, 16'h0A0A);
    chk("R4 head A tag", head_tag, 2'b00);
    issue_ready = 1'b1; #1;
    chk("R5 untagged issues", issue, 1);
    tick();
    chk("R4 head B", head_word, 16'h0B0B);
    chk("R4 tag travelled", head_tag, 2'b10);
    chk("R5 tagged dbg_req", dbg_req, 1);
    chk("R5 tagged no issue", issue, 0);
    tick();
    chk("R5 tagged held", head_word, 16'h0B0B);
    dbg_active = 1'b1; #1;
    chk("R7 same-cycle dbg_req", dbg_req, 0);
    tick();
    dbg_active = 1'b0; #1;
    chk("R7 disarmed", cmd_block, 0);
    chk("R7 tagged issues", issue, 1);
    tick();
    chk("R4 head C", head_word, 16'h0C0C);
    tick();
    issue_ready = 1'b0; #1;
    chk("R9 fourth dropped", head_valid, 0);

    // R8 flush drops pending tag
    do_arm();
    fetch(16'h3333);
    bus_fall(1'b0, 1'b0);
    do_flush();
    chk("R8 flushed empty", head_valid, 0);
    fetch(16'h4444);
    chk("R8 pending cleared", head_tag, 2'b00);
    chk("R8 word", head_word, 16'h4444);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule